// File: doc/BRIEF.md
# Keypad Controller Command Decoder

This block sits behind a byte-level serial bus target and turns byte transactions into register operations for a keypad and GPIO controller. Each write transaction opens with a command code. Any bytes that follow are parameters for that command, and each carries a running byte index. A read transaction returns the bytes of the response to whichever command was selected last. The block holds the controller's settings: configuration, active time, debounce, keypad geometry, clock selection, and the three 16-bit GPIO words (pull, direction, level). It also keeps a sticky error register and the two interrupt-status flags that error reporting drives.

When a command has taken all the bytes it needs, the selected code drops to an idle value, 0xFF. Any further byte is then reported as a bad parameter. Every setter checks its value against its legal range. Out-of-range values are still stored, but an error flag is raised. Scanning, the key FIFO itself and PWM timing live elsewhere. Toward the FIFO, this block gives only a flush pulse and two overflow event inputs.

Top module: `kpd_cmd_decoder`

## Requirements
- R1: In a write transaction, the first byte is stored as the selected command. Later bytes are parameters with index 0, 1, 2 and so on. Both the write-start strobe and the read-start strobe clear the byte position to 0, and each write byte or read request moves it on by one.
- R2: Command 0x83 with parameter 0xAA restores config 0x80, status 0x10, active time 125, debounce 3, keypad size 0x33 and clock 0x08. Any other parameter leaves these values alone and sets error bit 0. Either way the command goes idle.
- R3: Commands 0x8B (active time), 0x8F (debounce), 0x90 (keypad size) and 0x93 (clock) store their single parameter and then go idle (0xFF). A parameter byte sent while the command is idle sets error bit 0.
- R4: The following values set error bit 0 but are still stored: a debounce of 0; a keypad size whose high nibble is outside 3..8 or whose low nibble is outside 3..12; a clock value whose bits [1:0] are 01 or 10.
- R5: GPIO commands 0x84 (pull), 0x85 (direction) and 0x86 (level) take the low byte at index 0 and the high byte at index 1. The index-0 byte clears the high byte. The command goes idle after the high byte.
- R6: The read responses are as follows. 0x80 returns 0x00 then 0x04, then 0x00 after that. 0x92 returns the low nibble of config. 0x94 returns (clock & 0xFC) | 0x02. 0x91 returns the keypad size. 0x8C returns the error register. 0x8E returns 0.
- R7: Reads of 0x87 (direction) and 0x88 (level) return byte N of the 16-bit word, that is, the word shifted right by 8×N. Bytes 2 and beyond return 0.
- R8: A write parameter or a read under an unrecognised command, including a read while idle, sets error bit 1. Such a read returns 0x00.
- R9: The error bits are bit 0 bad parameter, bit 1 unknown command, bit 2 key overrun (from key_ovr_evt) and bit 6 FIFO overflow (from fifo_ovf_evt). Error bits are never cleared except by hardware reset. Any error being set also sets status bit 3.
- R10: Command 0x81 stores its byte as config, clears the status to 0, sends a one-cycle pulse on fifo_flush, and goes idle.
- R11: For commands 0x95, 0x96 and 0x97, a parameter whose bits [1:0] are 00 or whose bits [7:2] are above 59 sets error bit 0, and the command goes idle. A 0x95 with a valid parameter takes two more bytes and then goes idle. A 0x96 or 0x97 goes idle after one byte.
- R12: Hardware reset gives the defaults listed in R2, GPIO words of 0, an error register of 0, an idle command, a byte position of 0 and read data of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Start of a write transaction |
| rd_start | input | 1 | Start of a read transaction |
| wr_valid | input | 1 | Write byte strobe |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Read byte request; response appears on rd_data the next cycle |
| key_ovr_evt | input | 1 | Key overrun event from the scanner |
| fifo_ovf_evt | input | 1 | Key FIFO overflow event |
| rd_data | output | 8 | Registered read response |
| cfg_q | output | 8 | Configuration register |
| active_q | output | 8 | Active time |
| debounce_q | output | 8 | Debounce time |
| kpsize_q | output | 8 | Keypad geometry, rows high nibble, columns low nibble |
| clksel_q | output | 8 | Clock selection |
| gpio_pull_q | output | 16 | GPIO pull selection |
| gpio_dir_q | output | 16 | GPIO direction |
| gpio_lvl_q | output | 16 | GPIO level |
| err_q | output | 8 | Sticky error register |
| int_status_q | output | 8 | Status: bit 3 error, bit 4 not initialised |
| fifo_flush | output | 1 | One-cycle pulse that empties the key FIFO |

## Verification
The assertions assume that at most one of wr_start, rd_start, wr_valid and rd_req is high in any cycle, which means a bus target delivers at most one event per clock. The bench drives each strobe as a single-cycle pulse set on the falling edge and never overlaps two of them. The bench puts every byte value through the range checks of the debounce, keypad-size, clock and PWM commands, applying a hardware reset between values so that each error flag is seen on its own.

// File: rtl/kpd_cmd_decoder.sv
module kpd_cmd_decoder #(
  parameter int          CNT_W    = 3,
  parameter logic [15:0] DEV_ID   = 16'h0400,
  parameter logic [3:0]  ROWS_MIN = 4'd3,
  parameter logic [3:0]  ROWS_MAX = 4'd8,
  parameter logic [3:0]  COLS_MIN = 4'd3,
  parameter logic [3:0]  COLS_MAX = 4'd12,
  parameter logic [5:0]  PWM_LAST = 6'd59
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_start,
  input  logic        rd_start,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        rd_req,
  input  logic        key_ovr_evt,
  input  logic        fifo_ovf_evt,
  output logic [7:0]  rd_data,
  output logic [7:0]  cfg_q,
  output logic [7:0]  active_q,
  output logic [7:0]  debounce_q,
  output logic [7:0]  kpsize_q,
  output logic [7:0]  clksel_q,
  output logic [15:0] gpio_pull_q,
  output logic [15:0] gpio_dir_q,
  output logic [15:0] gpio_lvl_q,
  output logic [7:0]  err_q,
  output logic [7:0]  int_status_q,
  output logic        fifo_flush
);
  localparam logic [7:0] C_ID    = 8'h80, C_CFG   = 8'h81, C_RST   = 8'h83,
                         C_PULL  = 8'h84, C_DIR   = 8'h85, C_LVL   = 8'h86,
                         C_RDIR  = 8'h87, C_RLVL  = 8'h88, C_ACT   = 8'h8B,
                         C_RERR  = 8'h8C, C_ROT   = 8'h8E, C_DBNC  = 8'h8F,
                         C_SIZE  = 8'h90, C_RSIZE = 8'h91, C_RCFG  = 8'h92,
                         C_CLK   = 8'h93, C_RCLK  = 8'h94, C_PWMW  = 8'h95,
                         C_PWMGO = 8'h96, C_PWMST = 8'h97, C_IDLE  = 8'hFF;
  localparam logic [7:0] RST_KEY  = 8'hAA;
  localparam logic [7:0] DEF_CFG  = 8'h80, DEF_STAT = 8'h10, DEF_ACT = 8'd125,
                         DEF_DBNC = 8'd3,  DEF_SIZE = 8'h33, DEF_CLK = 8'h08;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [7:0]       cmd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             param;
  logic             wr_bad, wr_unk, wr_end, rd_unk;
  logic             pwm_bad, size_bad;
  logic [7:0]       rd_val, err_set, stat_nxt;
  logic             cfg_wr, rst_wr;

  assign param    = wr_valid && (cnt_q != '0);
  assign idx      = cnt_q - ONE;
  assign pwm_bad  = (wr_data[1:0] == 2'b00) || (wr_data[7:2] > PWM_LAST);
  assign size_bad = (wr_data[3:0] < COLS_MIN) || (wr_data[3:0] > COLS_MAX) ||
                    (wr_data[7:4] < ROWS_MIN) || (wr_data[7:4] > ROWS_MAX);
  assign cfg_wr   = param && (cmd_q == C_CFG);
  assign rst_wr   = param && (cmd_q == C_RST) && (wr_data == RST_KEY);

  always_comb begin
    wr_bad = 1'b0;
    wr_unk = 1'b0;
    wr_end = 1'b0;
    case (cmd_q)
      C_CFG, C_ACT:            wr_end = 1'b1;
      C_RST:   begin wr_end = 1'b1; wr_bad = (wr_data != RST_KEY); end
      C_PULL, C_DIR, C_LVL:    wr_end = (idx != '0);
      C_DBNC:  begin wr_end = 1'b1; wr_bad = (wr_data == 8'h00); end
      C_SIZE:  begin wr_end = 1'b1; wr_bad = size_bad; end
      C_CLK:   begin wr_end = 1'b1; wr_bad = (wr_data[1] ^ wr_data[0]); end
      C_PWMW:  begin
        if (idx == '0) begin wr_bad = pwm_bad; wr_end = pwm_bad; end
        else           wr_end = (idx > ONE);
      end
      C_PWMGO, C_PWMST: begin wr_end = 1'b1; wr_bad = pwm_bad; end
      C_IDLE:                  wr_bad = 1'b1;
      default:                 wr_unk = 1'b1;
    endcase
  end

  always_comb begin
    rd_unk = 1'b0;
    case (cmd_q)
      C_ID:    rd_val = (cnt_q == '0) ? DEV_ID[7:0] : (cnt_q == ONE) ? DEV_ID[15:8] : 8'h00;
      C_RDIR:  rd_val = (cnt_q == '0) ? gpio_dir_q[7:0] : (cnt_q == ONE) ? gpio_dir_q[15:8] : 8'h00;
      C_RLVL:  rd_val = (cnt_q == '0) ? gpio_lvl_q[7:0] : (cnt_q == ONE) ? gpio_lvl_q[15:8] : 8'h00;
      C_RERR:  rd_val = err_q;
      C_ROT:   rd_val = 8'h00;
      C_RSIZE: rd_val = kpsize_q;
      C_RCFG:  rd_val = {4'h0, cfg_q[3:0]};
      C_RCLK:  rd_val = {clksel_q[7:2], 2'b10};
      default: begin rd_val = 8'h00; rd_unk = 1'b1; end
    endcase
  end

  assign err_set = {1'b0, fifo_ovf_evt, 3'b000, key_ovr_evt,
                    (param && wr_unk) || (rd_req && rd_unk), param && wr_bad};

  always_comb begin
    stat_nxt = int_status_q;
    if (cfg_wr) stat_nxt = 8'h00;
    if (rst_wr) stat_nxt = DEF_STAT;
    if (err_set != 8'h00) stat_nxt[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q        <= C_IDLE;
      cnt_q        <= '0;
      rd_data      <= 8'h00;
      cfg_q        <= DEF_CFG;
      active_q     <= DEF_ACT;
      debounce_q   <= DEF_DBNC;
      kpsize_q     <= DEF_SIZE;
      clksel_q     <= DEF_CLK;
      gpio_pull_q  <= 16'h0000;
      gpio_dir_q   <= 16'h0000;
      gpio_lvl_q   <= 16'h0000;
      err_q        <= 8'h00;
      int_status_q <= DEF_STAT;
      fifo_flush   <= 1'b0;
    end else begin
      fifo_flush   <= cfg_wr;
      err_q        <= err_q | err_set;
      int_status_q <= stat_nxt;
      if (wr_start || rd_start)                     cnt_q <= '0;
      else if ((wr_valid || rd_req) && cnt_q != CNT_TOP) cnt_q <= cnt_q + ONE;
      if (rd_req) rd_data <= rd_val;
      if (wr_valid && cnt_q == '0) cmd_q <= wr_data;
      if (param) begin
        if (wr_end) cmd_q <= C_IDLE;
        case (cmd_q)
          C_CFG:  cfg_q      <= wr_data;
          C_ACT:  active_q   <= wr_data;
          C_DBNC: debounce_q <= wr_data;
          C_SIZE: kpsize_q   <= wr_data;
          C_CLK:  clksel_q   <= wr_data;
          C_PULL: if (idx == '0) gpio_pull_q <= {8'h00, wr_data}; else if (idx == ONE) gpio_pull_q[15:8] <= wr_data;
          C_DIR:  if (idx == '0) gpio_dir_q  <= {8'h00, wr_data}; else if (idx == ONE) gpio_dir_q[15:8]  <= wr_data;
          C_LVL:  if (idx == '0) gpio_lvl_q  <= {8'h00, wr_data}; else if (idx == ONE) gpio_lvl_q[15:8]  <= wr_data;
          C_RST: if (wr_data == RST_KEY) begin
            cfg_q      <= DEF_CFG;
            active_q   <= DEF_ACT;
            debounce_q <= DEF_DBNC;
            kpsize_q   <= DEF_SIZE;
            clksel_q   <= DEF_CLK;
          end
          default: ;
        endcase
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_start, rd_start, wr_valid, rd_req})); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start || rd_start) |=> (cnt_q == '0)); // R1
  AST_IDLE_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cnt_q != '0 && cmd_q == C_IDLE) |=> err_q[0]); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(err_q)) == $past(err_q))); // R9
  AST_ERR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != $past(err_q)) |-> int_status_q[3]); // R9
  AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cnt_q != '0 && cmd_q == C_RST && wr_data == RST_KEY) |=>
    (cfg_q == DEF_CFG && active_q == DEF_ACT && kpsize_q == DEF_SIZE && cmd_q == C_IDLE)); // R2
  AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cnt_q != '0 && cmd_q == C_CFG) |=> (fifo_flush && cmd_q == C_IDLE)); // R10
endmodule

// File: tb/kpd_cmd_decoder_bench.sv
module kpd_cmd_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 0, rd_start = 0, wr_valid = 0, rd_req = 0;
  logic key_ovr_evt = 0, fifo_ovf_evt = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, cfg_q, active_q, debounce_q, kpsize_q, clksel_q, err_q, int_status_q;
  logic [15:0] gpio_pull_q, gpio_dir_q, gpio_lvl_q;
  logic fifo_flush;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  kpd_cmd_decoder u_kpd_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .key_ovr_evt(key_ovr_evt), .fifo_ovf_evt(fifo_ovf_evt), .rd_data(rd_data),
    .cfg_q(cfg_q), .active_q(active_q), .debounce_q(debounce_q), .kpsize_q(kpsize_q),
    .clksel_q(clksel_q), .gpio_pull_q(gpio_pull_q), .gpio_dir_q(gpio_dir_q),
    .gpio_lvl_q(gpio_lvl_q), .err_q(err_q), .int_status_q(int_status_q),
    .fifo_flush(fifo_flush));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask
  task automatic begin_wr();
    @(negedge clk) wr_start = 1'b1;
    @(negedge clk) wr_start = 1'b0;
  endtask
  task automatic begin_rd();
    @(negedge clk) rd_start = 1'b1;
    @(negedge clk) rd_start = 1'b0;
  endtask
  task automatic put(input logic [7:0] b);
    @(negedge clk) begin wr_valid = 1'b1; wr_data = b; end
    @(negedge clk) wr_valid = 1'b0;
  endtask
  task automatic get(output logic [7:0] v);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    v = rd_data;
  endtask
  task automatic cmd1(input logic [7:0] c, input logic [7:0] v);
    begin_wr(); put(c); put(v);
  endtask
  task automatic sel_rd(input logic [7:0] c);
    begin_wr(); put(c); begin_rd();
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    hw_reset();
    chk("R12 cfg", cfg_q, 16'h80);
    chk("R12 status", int_status_q, 16'h10);
    chk("R12 active", active_q, 16'd125);
    chk("R12 debounce", debounce_q, 16'd3);
    chk("R12 size", kpsize_q, 16'h33);
    chk("R12 clock", clksel_q, 16'h08);
    chk("R12 err", err_q, 16'h00);
    chk("R12 gpio", gpio_dir_q | gpio_pull_q | gpio_lvl_q, 16'h0000);
    chk("R12 rd_data", rd_data, 16'h00);

    // R1, R3: setter then extra byte at idle
    cmd1(8'h8B, 8'h55);
    chk("R1 active stored", active_q, 16'h55);
    chk("R3 no error yet", err_q, 16'h00);
    put(8'h66);
    chk("R3 extra byte bad", err_q, 16'h01);
    chk("R3 value kept", active_q, 16'h55);
    chk("R9 status bit3", int_status_q, 16'h18);

    // R4 sweeps
    for (int x = 0; x < 256; x++) begin
      int lo, hi;
      lo = x & 15; hi = x >> 4;
      hw_reset(); cmd1(8'h90, 8'(x));
      chk("R4 size stored", kpsize_q, 16'(x));
      chk("R4 size flag", err_q, (lo < 3 || lo > 12 || hi < 3 || hi > 8) ? 16'h01 : 16'h00);
      hw_reset(); cmd1(8'h8F, 8'(x));
      chk("R4 debounce stored", debounce_q, 16'(x));
      chk("R4 debounce flag", err_q, (x == 0) ? 16'h01 : 16'h00);
      hw_reset(); cmd1(8'h93, 8'(x));
      chk("R4 clock stored", clksel_q, 16'(x));
      chk("R4 clock flag", err_q, ((x & 3) == 1 || (x & 3) == 2) ? 16'h01 : 16'h00);
    end

    // R11 sweeps
    for (int c = 0; c < 3; c++) begin
      for (int x = 0; x < 256; x++) begin
        logic bp;
        bp = ((x & 3) == 0) || ((x >> 2) > 59);
        hw_reset(); cmd1(8'(8'h95 + c), 8'(x));
        chk("R11 pwm flag", err_q, bp ? 16'h01 : 16'h00);
        if (c == 0 && !bp) begin
          put(8'h12); put(8'h34);
          chk("R11 pwm write takes 2 more", err_q, 16'h00);
        end
        put(8'h00);
        chk("R11 pwm idle afterwards", err_q, 16'h01);
      end
    end

    // R5, R7 GPIO words
    hw_reset();
    begin_wr(); put(8'h85); put(8'hC3); put(8'h5A);
    chk("R5 dir word", gpio_dir_q, 16'h5AC3);
    chk("R5 no error", err_q, 16'h00);
    put(8'h01);
    chk("R5 idle after high byte", err_q, 16'h01);
    begin_wr(); put(8'h86); put(8'h77);
    chk("R5 low byte clears high", gpio_lvl_q, 16'h0077);
    put(8'h9E);
    chk("R5 level word", gpio_lvl_q, 16'h9E77);
    cmd1(8'h84, 8'hF0); put(8'h0F);
    chk("R5 pull word", gpio_pull_q, 16'h0FF0);
    sel_rd(8'h87);
    get(v); chk("R7 dir byte0", v, 16'hC3);
    get(v); chk("R7 dir byte1", v, 16'h5A);
    get(v); chk("R7 dir byte2", v, 16'h00);
    sel_rd(8'h88);
    get(v); chk("R7 level byte0", v, 16'h77);
    get(v); chk("R7 level byte1", v, 16'h9E);
    begin_rd();
    get(v); chk("R1 rd_start rewinds", v, 16'h77);

    // R6 reads
    hw_reset();
    sel_rd(8'h80);
    get(v); chk("R6 id byte0", v, 16'h00);
    get(v); chk("R6 id byte1", v, 16'h04);
    get(v); chk("R6 id byte2", v, 16'h00);
    cmd1(8'h93, 8'hFF);
    sel_rd(8'h94); get(v); chk("R6 clock read", v, 16'hFE);
    sel_rd(8'h91); get(v); chk("R6 size read", v, 16'h33);
    sel_rd(8'h8E); get(v); chk("R6 rotator read", v, 16'h00);
    chk("R6 no error", err_q, 16'h00);

    // R10 config write
    @(negedge clk) key_ovr_evt = 1'b1;
    @(negedge clk) key_ovr_evt = 1'b0;
    chk("R9 key overrun bit2", err_q, 16'h04);
    chk("R9 status bit3 set", int_status_q, 16'h18);
    begin_wr(); put(8'h81);
    @(negedge clk) begin wr_valid = 1'b1; wr_data = 8'hA7; end
    @(negedge clk) wr_valid = 1'b0;
    chk("R10 flush pulse", fifo_flush, 16'h1);
    chk("R10 status cleared", int_status_q, 16'h00);
    chk("R10 cfg stored", cfg_q, 16'hA7);
    @(negedge clk);
    chk("R10 flush one cycle", fifo_flush, 16'h0);
    sel_rd(8'h92); get(v); chk("R6 cfg low nibble", v, 16'h07);
    sel_rd(8'h8C); get(v); chk("R9 error sticky via read", v, 16'h04);
    begin_wr(); put(8'h81); put(8'h00); put(8'h00);
    chk("R10 idle after config", err_q, 16'h05);

    // R2 reset command
    hw_reset();
    cmd1(8'h8B, 8'h11); cmd1(8'h90, 8'h48); cmd1(8'h81, 8'h0F);
    cmd1(8'h83, 8'h12);
    chk("R2 bad key flag", err_q, 16'h01);
    chk("R2 bad key keeps", active_q, 16'h11);
    cmd1(8'h83, 8'hAA);
    chk("R2 cfg", cfg_q, 16'h80);
    chk("R2 active", active_q, 16'd125);
    chk("R2 size", kpsize_q, 16'h33);
    chk("R2 status", int_status_q, 16'h10);
    chk("R2 err kept", err_q, 16'h01);
    put(8'h00);
    chk("R2 idle after", err_q, 16'h01);

    // R8 unknown commands, R9 FIFO overflow
    hw_reset();
    cmd1(8'h8D, 8'h00);
    chk("R8 unknown write", err_q, 16'h02);
    hw_reset();
    sel_rd(8'h8A); get(v);
    chk("R8 unknown read data", v, 16'h00);
    chk("R8 unknown read flag", err_q, 16'h02);
    hw_reset();
    begin_rd(); get(v);
    chk("R8 read at idle", err_q, 16'h02);
    @(negedge clk) fifo_ovf_evt = 1'b1;
    @(negedge clk) fifo_ovf_evt = 1'b0;
    chk("R9 fifo overflow bit6", err_q, 16'h42);
    chk("R9 status", int_status_q, 16'h18);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule